// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block holds the clock control word of an SD host and produces the clock sent to the card. Software writes a 16-bit word that carries a divider code, an internal clock enable and a card clock enable. Reading the word back returns the stored fields plus a read-only flag that reports when the internal divided clock has settled. The card clock output runs only after that flag is set and the card enable is on. It is gated so that every high pulse it emits is complete.

The divider does not use plain binary ratios. The supported ratios are 1, 2, 3 and 4, then powers of two up to 256. Ratio 3 has a dedicated code, and every other ratio is encoded as half its value. Codes outside the supported set round up to the next supported ratio. The block runs from a reference clock at twice the card base rate. A divide ratio N gives a card clock that is high for N reference cycles and low for N reference cycles.

The intended bring-up order is as follows. Write the code with the internal enable set. Poll until the settled flag reads one. Then set the card enable. Writing zero stops everything.

Top module: `sdclk_unit`

## Requirements
- R1: After reset the read word is 0x0000 and `card_clk` is low.
- R2: Word layout: bits 15:8 divider code, bit 2 card enable, bit 1 settled flag (read-only; a written value is ignored), bit 0 internal enable; bits 7:3 read as zero.
- R3: Code to ratio: 0→1, 1→2, 2→4, 3→3, 4→8, 8→16, 16→32, 32→64, 64→128, 128→256. With ratio N the card clock is high N cycles and low N cycles.
- R4: Any other code c requests ratio 2·c and is rounded up to the next supported ratio, capped at 256 (5→16, 6→16, 9→32, 100→256, 129→256, 255→256).
- R5: A write that sets the internal enable, either when it was clear or with a code different from the stored one, clears the settled flag. The flag then reads one exactly STABLE_CYC cycles after that write's clock edge.
- R6: A write with the internal enable clear makes the settled flag read zero from the next cycle. Writing 0x0000 reads back 0x0000 and stops the card clock.
- R7: Rewriting the same code with the internal enable already set leaves the settled flag set.
- R8: `card_clk` never starts a high pulse unless, in the cycle before, the card enable and the settled flag both read one.
- R9: Clearing the card enable while `card_clk` is high lets that pulse finish at its full length N. After that the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the card base rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word including settled flag |
| card_clk | output | 1 | Gated divided clock to the card |

## Verification
The bench measures the high and low run lengths of the card clock for every supported code. It does the same for several unsupported codes. A wrong decode, including a missing special case for ratio 3 or a wrong round-up, shows up as a wrong run length.

The bench counts the cycles until the settled flag appears after an enable and after a code change. An off-by-one counter, or a flag that ignores a code change, fails that count. The bench also checks that rewriting the same code leaves the flag set.

The card enable is cleared in the middle of a high pulse. A gate that acts at once cuts the pulse short, and a gate that never closes keeps toggling; either fault is caught. The bench also confirms that writes to the read-only flag and to the reserved bits have no visible effect.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int WORD_W  = 16;
    localparam int CODE_W  = 8;
    localparam int RATIO_W = 9;
    localparam int MAX_RATIO = 256;

    // control word field positions
    localparam int CODE_LSB  = 8;
    localparam int BIT_RUN   = 0;
    localparam int BIT_READY = 1;
    localparam int BIT_CARD  = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              card_en;
        logic              run_en;
    } clk_cfg_t;

    // map a divider code to its divide ratio
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        int want;
        want = 2 * int'(c);
        r = RATIO_W'(MAX_RATIO);
        if (c == '0) begin
            r = RATIO_W'(1);
        end else if (c == CODE_W'(3)) begin
            r = RATIO_W'(3);
        end else begin
            for (int k = 8; k >= 1; k--) begin
                if ((1 << k) >= want) r = RATIO_W'(1 << k);
            end
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input clk_cfg_t cfg, input logic ready);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CODE_LSB +: CODE_W] = cfg.code;
        w[BIT_CARD]  = cfg.card_en;
        w[BIT_READY] = ready;
        w[BIT_RUN]   = cfg.run_en;
        return w;
    endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output clk_cfg_t          cfg,
    output logic              ready,
    output logic              div_clear
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);

    clk_cfg_t          cfg_q;
    logic [CNT_W-1:0]  settle_q;
    logic              restart;
    logic [CODE_W-1:0] new_code;

    assign new_code = wr_data[CODE_LSB +: CODE_W];
    assign restart  = wr_en && wr_data[BIT_RUN] &&
                      (!cfg_q.run_en || (new_code != cfg_q.code));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            settle_q <= '0;
        end else begin
            if (wr_en) begin
                cfg_q.code    <= new_code;
                cfg_q.card_en <= wr_data[BIT_CARD];
                cfg_q.run_en  <= wr_data[BIT_RUN];
            end
            if (restart) begin
                settle_q <= CNT_W'(STABLE_CYC);
            end else if (cfg_q.run_en && settle_q != '0) begin
                settle_q <= settle_q - 1'b1;
            end
        end
    end

    assign cfg       = cfg_q;
    assign ready     = cfg_q.run_en && (settle_q == '0);
    assign div_clear = restart || (wr_en && !wr_data[BIT_RUN]) || !cfg_q.run_en;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [CODE_W-1:0] code,
    output logic              div_q,
    output logic              div_next
);
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half_q;
    logic [RATIO_W-1:0] half_next;

    assign ratio = ratio_of(code);

    always_comb begin
        half_next = '0;
        div_next  = 1'b0;
        if (!clear) begin
            if (half_q >= ratio - 1'b1) begin
                half_next = '0;
                div_next  = !div_q;
            end else begin
                half_next = half_q + 1'b1;
                div_next  = div_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
            div_q  <= 1'b0;
        end else begin
            half_q <= half_next;
            div_q  <= div_next;
        end
    end

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic div_q,
    input  logic div_next,
    output logic card_clk
);
    logic gate_q;
    logic gate_eff;
    logic card_q;

    // the gate may only move while the divided clock is low
    assign gate_eff = div_q ? gate_q : want;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            card_q <= 1'b0;
        end else begin
            gate_q <= gate_eff;
            card_q <= div_next && gate_eff;
        end
    end

    assign card_clk = card_q;

endmodule

// File: rtl/sdclk_unit.sv
module sdclk_unit
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        card_clk
);
    clk_cfg_t cfg;
    logic     ready;
    logic     div_clear;
    logic     div_q;
    logic     div_next;

    sdclk_ctrl_reg #(.STABLE_CYC(STABLE_CYC)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .ready     (ready),
        .div_clear (div_clear)
    );

    sdclk_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .clear    (div_clear),
        .code     (cfg.code),
        .div_q    (div_q),
        .div_next (div_next)
    );

    sdclk_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .want     (cfg.card_en && ready),
        .div_q    (div_q),
        .div_next (div_next),
        .card_clk (card_clk)
    );

    assign rd_data = pack_word(cfg, ready);

endmodule

// File: rtl/sdclk_unit_chk.sv
module sdclk_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        card_clk
);
    // R2: reserved bits read as zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:3] == 5'd0);

    // R6: settled flag implies internal enable
    p_ready_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[1] |-> rd_data[0]);

    // R6: a write clearing the internal enable drops the flag
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0]) |=> !rd_data[1]);

    // R5: a restarting write clears the flag in the next cycle
    p_ready_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0] && (!rd_data[0] || wr_data[15:8] != rd_data[15:8]))
        |=> !rd_data[1]);

    // R8: a card pulse starts only when enabled and settled
    p_card_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk) |-> $past(rd_data[2] && rd_data[1]));

    // R1: outputs clear during reset
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 16'h0000 && !card_clk));

endmodule

bind sdclk_unit sdclk_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .card_clk (card_clk)
);

// File: tb/tb_sdclk_unit.sv
module tb_sdclk_unit;
    localparam int S = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        card_clk;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    sdclk_unit #(.STABLE_CYC(S)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_clk(card_clk)
    );

    always #10 clk = ~clk;

    // driver side: expected items
    task automatic expect_val(input string tag, input int v);
        item_t it;
        it.tag = tag; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input string tag, input int v);
        item_t it;
        it.tag = tag; it.val = v;
        act_q.push_back(it);
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        while (act_q.size() > 0) begin
            item_t a;
            item_t e;
            a = act_q.pop_front();
            n_total++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected (none queued)", a.tag, a.val);
            end else begin
                e = exp_q.pop_front();
                if (a.val != e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a.val, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic measure(input string tag, input int ratio);
        int h;
        int l;
        int guard;
        h = 0; l = 0; guard = 0;
        while (card_clk && guard < 2000) begin @(negedge clk); guard++; end
        while (!card_clk && guard < 2000) begin @(negedge clk); guard++; end
        while (card_clk && guard < 2000) begin h++; @(negedge clk); guard++; end
        while (!card_clk && guard < 2000) begin l++; @(negedge clk); guard++; end
        expect_val({tag, " high"}, ratio); observe({tag, " high"}, h);
        expect_val({tag, " low"}, ratio);  observe({tag, " low"}, l);
    endtask

    task automatic settle_check(input string tag);
        int early;
        early = 0;
        for (int i = 0; i < S - 1; i++) begin
            if (rd_data[1] || card_clk) early++;
            @(negedge clk);
        end
        if (rd_data[1] || card_clk) early++;
        expect_val({tag, " flag/card low while settling"}, 0); observe({tag, " flag/card low while settling"}, early);
        @(negedge clk);
        expect_val({tag, " flag set after settle"}, 1); observe({tag, " flag set after settle"}, int'(rd_data[1]));
    endtask

    task automatic run_code(input logic [7:0] code, input int ratio, input string tag);
        wr({code, 8'h05});
        settle_check({tag, " R5"});
        measure(tag, ratio);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int highs;
        int h;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_val("R1 word after reset", 0); observe("R1 word after reset", int'(rd_data));
        expect_val("R1 card after reset", 0); observe("R1 card after reset", int'(card_clk));
        rst = 1'b0;

        // R2 layout, read-only flag, reserved bits; R4 code 255
        wr(16'hFFFF);
        expect_val("R2 readback with flag clear", 32'hFF05); observe("R2 readback with flag clear", int'(rd_data));
        repeat (S) @(negedge clk);
        expect_val("R2 readback settled", 32'hFF07); observe("R2 readback settled", int'(rd_data));
        measure("R4 code 255", 256);

        // R6 all-zero write stops everything
        wr(16'h0000);
        expect_val("R6 zero readback", 0); observe("R6 zero readback", int'(rd_data));
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) highs++;
            @(negedge clk);
        end
        expect_val("R6 card stopped", 0); observe("R6 card stopped", highs);

        // R3 supported codes
        run_code(8'd0,   1,   "R3 code 0");
        run_code(8'd1,   2,   "R3 code 1");
        run_code(8'd2,   4,   "R3 code 2");
        run_code(8'd3,   3,   "R3 code 3");
        run_code(8'd4,   8,   "R3 code 4");
        run_code(8'd8,   16,  "R3 code 8");
        run_code(8'd16,  32,  "R3 code 16");
        run_code(8'd32,  64,  "R3 code 32");
        run_code(8'd64,  128, "R3 code 64");
        run_code(8'd128, 256, "R3 code 128");
        // R4 rounding
        run_code(8'd5,   16,  "R4 code 5");
        run_code(8'd6,   16,  "R4 code 6");
        run_code(8'd9,   32,  "R4 code 9");
        run_code(8'd100, 256, "R4 code 100");
        run_code(8'd129, 256, "R4 code 129");

        // R7 same code rewrite keeps flag
        wr({8'd129, 8'h05});
        expect_val("R7 flag kept", 1); observe("R7 flag kept", int'(rd_data[1]));

        // R9 clear card enable mid-pulse
        run_code(8'd2, 4, "R9 setup");
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h0201;
        h = 1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        while (card_clk && h < 100) begin h++; @(negedge clk); end
        expect_val("R9 pulse finished full length", 4); observe("R9 pulse finished full length", h);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) highs++;
            @(negedge clk);
        end
        expect_val("R8 card low with enable clear", 0); observe("R8 card low with enable clear", highs);
        expect_val("R8 flag still set", 32'h0203); observe("R8 flag still set", int'(rd_data));

        // R6 clearing internal enable only
        wr(16'h0204);
        expect_val("R6 flag dropped", 32'h0204); observe("R6 flag dropped", int'(rd_data));
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) highs++;
            @(negedge clk);
        end
        expect_val("R8 card low while not settled", 0); observe("R8 card low while not settled", highs);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule